// File: doc/BRIEF.md
# Pipelined Modulo-16 Matrix Inverter

This block takes a 3x3 matrix of 4-bit entries and returns its inverse in arithmetic modulo 16. In a linear block cipher, the same multiplier serves for both directions, so this block derives the deciphering key from the loaded enciphering key. A new matrix can be presented on every clock. Its inverse appears at the output a fixed four cycles later.

Inside, the work is split into four register stages. The first forms the eighteen pairwise products. The second subtracts them into cofactors and stores them transposed as the adjugate. The third sums the determinant from the first key row and looks up its reciprocal. The last scales every adjugate entry by that reciprocal. A matrix with an even determinant has no inverse modulo 16. The reciprocal is then zero, so the whole output is zero, and no separate flag is raised.

Top module: `mat3_inv_mod16`

## Requirements
- R1: Both matrix buses carry entry (row r, column c), with r and c counted 0..2, in bits [(3*r+c)*4 +: 4]. Row 0 column 0 sits in the lowest nibble.
- R2: For any key with an odd determinant, the key matrix multiplied by the output matrix equals the identity modulo 16.
- R3: The output is the adjugate (transposed cofactors) scaled by the reciprocal of the determinant, all modulo 16. For example, diag(3,5,7) yields diag(11,13,7).
- R4: The reciprocal of an odd determinant d is the value x with d*x = 1 mod 16: 1→1, 3→11, 5→13, 7→7, 9→9, 11→3, 13→5, 15→15.
- R5: A key whose determinant is even (0, 2, ..., 14) gives an all-zero output.
- R6: The output reflects the key sampled at the fourth rising edge before it. Through the three edges before that, it still shows the previous key's result.
- R7: A different key may be applied on every cycle. Consecutive keys produce consecutive results, one per cycle.
- R8: Reset is synchronous and active low. After a rising edge with rst_n low, the output is all zeros. After release, the output stays zero until the pipeline refills, four edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of all pipeline stages |
| key_in | input | 36 | Matrix to invert, nine 4-bit entries in row-major nibbles |
| key_out | output | 36 | Modulo-16 inverse, same layout, zero for non-invertible keys |

## Verification
The assertions rely on the adjugate identity: any key row times any adjugate column gives the determinant on the diagonal and zero off it. They also assume the reciprocal stage sees only 4-bit residues. Both hold for every possible input, so the stimulus is free to include even determinants, all-ones and all-fifteen matrices. Each key is held steady across its sampling edge. The only exception is the throughput test, which changes the key at every falling edge so that each rising edge samples a distinct matrix.

// File: rtl/hinv_pkg.sv
package hinv_pkg;

  localparam int unsigned DIM   = 3;
  localparam int unsigned CELLS = DIM * DIM;

  // Reciprocal of an odd residue modulo a power of two, by Newton iteration.
  // Each round doubles the number of correct low bits (3 -> 6 -> 12 -> 24 -> 48),
  // so five rounds cover any width up to 32. Even inputs return zero.
  function automatic logic [31:0] recip_odd(input logic [31:0] d);
    logic [31:0] x;
    if (!d[0]) return 32'd0;
    x = d;
    for (int i = 0; i < 5; i++) begin
      x = x * (32'd2 - d * x);
    end
    return x;
  endfunction

  // Cyclic successor of a row or column index in a 3x3 matrix.
  function automatic int unsigned nxt(input int unsigned i, input int unsigned step);
    return (i + step) % DIM;
  endfunction

endpackage

// File: rtl/hinv_product_stage.sv
module hinv_product_stage #(
  parameter int unsigned W = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [hinv_pkg::CELLS-1:0][W-1:0]  key_i,
  output logic [hinv_pkg::CELLS-1:0][W-1:0]  prod_pos_o,
  output logic [hinv_pkg::CELLS-1:0][W-1:0]  prod_neg_o,
  output logic [hinv_pkg::CELLS-1:0][W-1:0]  key_o
);
  import hinv_pkg::*;

  logic [CELLS-1:0][W-1:0] pos_c;
  logic [CELLS-1:0][W-1:0] neg_c;

  // Cofactor (r,c) uses the 2x2 minor on rows r+1,r+2 and columns c+1,c+2 (cyclic).
  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      localparam int unsigned R1 = nxt(r, 1);
      localparam int unsigned R2 = nxt(r, 2);
      localparam int unsigned C1 = nxt(c, 1);
      localparam int unsigned C2 = nxt(c, 2);
      localparam int unsigned IDX = r * DIM + c;
      assign pos_c[IDX] = key_i[R1*DIM+C1] * key_i[R2*DIM+C2];
      assign neg_c[IDX] = key_i[R1*DIM+C2] * key_i[R2*DIM+C1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_pos_o <= '0;
      prod_neg_o <= '0;
      key_o      <= '0;
    end else begin
      prod_pos_o <= pos_c;
      prod_neg_o <= neg_c;
      key_o      <= key_i;
    end
  end

endmodule

// File: rtl/hinv_cofactor_stage.sv
module hinv_cofactor_stage #(
  parameter int unsigned W = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [hinv_pkg::CELLS-1:0][W-1:0]  prod_pos_i,
  input  logic [hinv_pkg::CELLS-1:0][W-1:0]  prod_neg_i,
  input  logic [hinv_pkg::CELLS-1:0][W-1:0]  key_i,
  output logic [hinv_pkg::CELLS-1:0][W-1:0]  adj_o,
  output logic [hinv_pkg::CELLS-1:0][W-1:0]  key_o
);
  import hinv_pkg::*;

  logic [CELLS-1:0][W-1:0] adj_c;

  // Difference of the two minor products, stored transposed: adj(c,r) = cof(r,c).
  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      assign adj_c[c*DIM+r] = prod_pos_i[r*DIM+c] - prod_neg_i[r*DIM+c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adj_o <= '0;
      key_o <= '0;
    end else begin
      adj_o <= adj_c;
      key_o <= key_i;
    end
  end

endmodule

// File: rtl/hinv_det_stage.sv
module hinv_det_stage #(
  parameter int unsigned W = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [hinv_pkg::CELLS-1:0][W-1:0]  adj_i,
  input  logic [hinv_pkg::CELLS-1:0][W-1:0]  key_i,
  output logic [W-1:0]                       det_o,
  output logic [W-1:0]                       inv_o,
  output logic [hinv_pkg::CELLS-1:0][W-1:0]  adj_o
);
  import hinv_pkg::*;

  logic [W-1:0] det_c;
  logic [31:0]  recip_wide;
  logic [W-1:0] inv_c;
  // Named check terms: key row 1 against adjugate column 1, key row 0 against column 1.
  logic [W-1:0] diag_row1_c;
  logic [W-1:0] offdiag_row0_c;

  // Expansion along key row 0: adj(j,0) holds cof(0,j).
  always_comb begin
    det_c = '0;
    for (int j = 0; j < DIM; j++) begin
      det_c = det_c + key_i[j] * adj_i[j*DIM+0];
    end
  end

  always_comb begin
    diag_row1_c    = '0;
    offdiag_row0_c = '0;
    for (int k = 0; k < DIM; k++) begin
      diag_row1_c    = diag_row1_c    + key_i[DIM+k] * adj_i[k*DIM+1];
      offdiag_row0_c = offdiag_row0_c + key_i[k]     * adj_i[k*DIM+1];
    end
  end

  assign recip_wide = recip_odd({{(32-W){1'b0}}, det_c});
  assign inv_c      = recip_wide[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det_o <= '0;
      inv_o <= '0;
      adj_o <= '0;
    end else begin
      det_o <= det_c;
      inv_o <= inv_c;
      adj_o <= adj_i;
    end
  end

  AST_ADJ_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
    diag_row1_c == det_c); // R2
  AST_ADJ_OFFDIAG: assert property (@(posedge clk) disable iff (!rst_n)
    offdiag_row0_c == '0); // R2
  AST_RECIP_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    det_o[0] |-> ((det_o * inv_o) == W'(1))); // R4
  AST_RECIP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !det_o[0] |-> (inv_o == '0)); // R5

endmodule

// File: rtl/hinv_scale_stage.sv
module hinv_scale_stage #(
  parameter int unsigned W = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [W-1:0]                       inv_i,
  input  logic [hinv_pkg::CELLS-1:0][W-1:0]  adj_i,
  output logic [hinv_pkg::CELLS-1:0][W-1:0]  key_o
);
  import hinv_pkg::*;

  logic [CELLS-1:0][W-1:0] scaled_c;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assign scaled_c[i] = inv_i * adj_i[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) key_o <= '0;
    else        key_o <= scaled_c;
  end

  AST_ZERO_RECIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_i == '0) |=> (key_o == '0)); // R5

endmodule

// File: rtl/mat3_inv_mod16.sv
module mat3_inv_mod16 #(
  parameter int unsigned W = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [hinv_pkg::CELLS*W-1:0]          key_in,
  output logic [hinv_pkg::CELLS*W-1:0]          key_out
);
  import hinv_pkg::*;

  logic [CELLS-1:0][W-1:0] key_c;
  logic [CELLS-1:0][W-1:0] s1_pos, s1_neg, s1_key;
  logic [CELLS-1:0][W-1:0] s2_adj, s2_key;
  logic [W-1:0]            s3_det, s3_inv;
  logic [CELLS-1:0][W-1:0] s3_adj;
  logic [CELLS-1:0][W-1:0] s4_key;

  assign key_c   = key_in;
  assign key_out = s4_key;

  hinv_product_stage #(.W(W)) u_prod (
    .clk(clk), .rst_n(rst_n), .key_i(key_c),
    .prod_pos_o(s1_pos), .prod_neg_o(s1_neg), .key_o(s1_key));

  hinv_cofactor_stage #(.W(W)) u_cof (
    .clk(clk), .rst_n(rst_n), .prod_pos_i(s1_pos), .prod_neg_i(s1_neg),
    .key_i(s1_key), .adj_o(s2_adj), .key_o(s2_key));

  hinv_det_stage #(.W(W)) u_det (
    .clk(clk), .rst_n(rst_n), .adj_i(s2_adj), .key_i(s2_key),
    .det_o(s3_det), .inv_o(s3_inv), .adj_o(s3_adj));

  hinv_scale_stage #(.W(W)) u_scale (
    .clk(clk), .rst_n(rst_n), .inv_i(s3_inv), .adj_i(s3_adj), .key_o(s4_key));

  AST_EVEN_DET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !s3_det[0] |=> (key_out == '0)); // R5

endmodule

// File: tb/mat3_inv_mod16_tb.sv
`timescale 1ns/1ps
module mat3_inv_mod16_tb_top;

  localparam int W = 4;
  localparam logic [35:0] IDENT = 36'h100010001;

  // {invertible, key}
  localparam logic [36:0] VEC [10] = '{
    {1'b1, 36'h100010001},   // identity
    {1'b1, 36'h700050003},   // diag(3,5,7)
    {1'b1, 36'h100410321},   // upper triangular
    {1'b0, 36'h100010002},   // diag(2,1,1), det 2
    {1'b0, 36'h111111111},   // all ones, det 0
    {1'b0, 36'h101110011},   // cyclic, det 2
    {1'b1, 36'h100011012},   // det 1
    {1'b1, 36'hF00FF0FFF},   // all fifteen upper, det 15
    {1'b1, 36'h105010003},   // det 3
    {1'b1, 36'h100053021}    // det 15
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] key_in = '0;
  logic [35:0] key_out;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mat3_inv_mod16 #(.W(W)) dut_i (.clk(clk), .rst_n(rst_n), .key_in(key_in), .key_out(key_out));

  function automatic logic [35:0] matmul(input logic [35:0] a, input logic [35:0] b);
    logic [35:0] res = '0;
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 3; j++) begin
        int s = 0;
        for (int m = 0; m < 3; m++) s += int'(a[(i*3+m)*4 +: 4]) * int'(b[(m*3+j)*4 +: 4]);
        res[(i*3+j)*4 +: 4] = s[3:0];
      end
    end
    return res;
  endfunction

  function automatic logic [3:0] brute_inv(input int d);
    for (int x = 0; x < 16; x++) if (((d * x) % 16) == 1) return 4'(x);
    return 4'd0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 36'h0, 36'h1);
    finish_run();
  end

  initial begin
    // R8: reset state
    key_in = IDENT;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(key_out == '0, "R8 reset output", key_out, '0);
    rst_n = 1'b1;

    // Vector table: R2 for invertible keys, R5 for even determinants
    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      key_in = VEC[v][35:0];
      repeat (4) @(posedge clk);
      @(negedge clk);
      if (VEC[v][36]) check(matmul(key_in, key_out) == IDENT, "R2 key times inverse", matmul(key_in, key_out), IDENT);
      else            check(key_out == '0, "R5 even determinant", key_out, '0);
    end

    // R1: field layout on a non-symmetric key
    @(negedge clk);
    key_in = 36'h100410321;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(key_out == 36'h100C105E1, "R1 entry positions", key_out, 36'h100C105E1);

    // R6: latency, starting from identity settled
    key_in = IDENT;
    repeat (5) @(posedge clk);
    @(negedge clk);
    key_in = 36'h700050003;
    for (int e = 0; e < 3; e++) begin
      @(negedge clk);
      check(key_out == IDENT, "R6 previous result held", key_out, IDENT);
    end
    @(negedge clk);
    // R3: explicit adjugate scaling
    check(key_out == 36'h7000D000B, "R3 diag(3,5,7) inverse", key_out, 36'h7000D000B);

    // R7: back-to-back keys
    @(negedge clk); key_in = 36'h100010003;
    @(negedge clk); key_in = 36'h100010005;
    @(negedge clk); key_in = 36'h100010002;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(key_out == 36'h10001000B, "R7 first streamed key", key_out, 36'h10001000B);
    @(negedge clk);
    check(key_out == 36'h10001000D, "R7 second streamed key", key_out, 36'h10001000D);
    @(negedge clk);
    check(key_out == '0, "R7 third streamed key", key_out, '0);

    // R4 and R5: reciprocal for every determinant through diag(d,1,1)
    for (int d = 0; d < 16; d++) begin
      logic [35:0] exp;
      @(negedge clk);
      key_in = 36'h100010000 | 36'(d);
      repeat (4) @(posedge clk);
      @(negedge clk);
      exp = (d % 2 == 1) ? (36'h100010000 | 36'(brute_inv(d))) : 36'h0;
      if (d % 2 == 1) check(key_out == exp, "R4 reciprocal", key_out, exp);
      else            check(key_out == exp, "R5 even reciprocal", key_out, exp);
    end

    // R8: reset mid-run and refill
    @(negedge clk);
    key_in = IDENT;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(key_out == IDENT, "R8 settled before reset", key_out, IDENT);
    rst_n = 1'b0;
    @(negedge clk);
    check(key_out == '0, "R8 cleared by reset", key_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(key_out == '0, "R8 empty after release", key_out, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(key_out == IDENT, "R8 refilled", key_out, IDENT);

    finish_run();
  end

endmodule